// File: doc/BRIEF.md
# ADC Input and Reference Select Register with Deferred Apply

This block is the 8-bit control register that sits between a register bus and an analog-to-digital converter front end. It stores three things: a 2-bit reference code, a result-alignment flag and a 5-bit channel/gain code. A bus write always updates the visible register on the next clock edge. Reads always return that visible value.

The converter does not see the visible register directly. It sees separate effective reference and effective channel outputs. These are copied from the visible register only when no conversion is running, or on the cycle that signals the end of a conversion. This way, a write made during a conversion cannot disturb the sample that is already in progress. When several writes land during one conversion, the last one is the value that gets applied.

The alignment flag is the exception. It acts at once. The block builds a 16-bit data view of the 10-bit conversion result, placed in either the upper or the lower part of the word, and the placement follows the visible flag without waiting for the conversion to end.

Top module: `adc_chsel_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, `eff_ref` is 0 and `eff_chan` is 0.
- R2: A write with `wr_en`=1 makes `rd_data` equal to `wr_data` from the following clock edge on, for all eight bits. Bits 7:6 hold the reference code, bit 5 holds the alignment flag and bits 4:0 hold the channel code.
- R3: While `conv_busy` is 0, a write sets `eff_ref` to `wr_data[7:6]` and `eff_chan` to `wr_data[4:0]` at the same clock edge that updates `rd_data`.
- R4: While `conv_busy` is 1 and `conv_done` is 0, `eff_ref` does not change, whatever is written.
- R5: While `conv_busy` is 1 and `conv_done` is 0, `eff_chan` does not change, whatever is written.
- R6: At the clock edge where `conv_done` is 1, `eff_ref` and `eff_chan` take the reference and channel fields of the most recently written value. If several writes were made during the conversion, only the last one is applied.
- R7: The alignment flag (bit 5) changes the placement in `data_view` from the edge after the write, even while `conv_busy` is 1.
- R8: When the alignment flag is 1, `data_view` equals `raw_result` in bits 15:6, with zeros in bits 5:0.
- R9: When the alignment flag is 0, `data_view` equals `raw_result` in bits 9:0, with zeros in bits 15:10.
- R10: During a conversion, `rd_data` returns the last written value, not the deferred effective fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Visible register value |
| conv_busy | input | 1 | A conversion is in progress |
| conv_done | input | 1 | Conversion completes this cycle |
| raw_result | input | 10 | Raw conversion result |
| eff_ref | output | 2 | Applied reference code: 0 = external pin with internal off, 1 = analog supply, 2 = internal 1.1 V, 3 = internal 2.56 V |
| eff_chan | output | 5 | Applied channel/gain code; codes 0 to 5 select single-ended inputs 0 to 5 |
| data_view | output | 16 | Aligned 16-bit result |

## Verification
The bound checker looks at these properties on every cycle:
- the effective fields hold steady through a conversion that has not finished;
- after an idle or completion edge, the effective fields match the visible register;
- `rd_data` reads back each write;
- `data_view` matches the placement chosen by the visible flag.

Some behaviour can only be shown by the bench's scenarios, because they depend on a sequence of events rather than on any single cycle:
- that the last of several writes made during one conversion is the one applied;
- that a write made mid-conversion leaves the previous effective value in place for several cycles;
- that the alignment flag takes effect while the effective fields are still frozen.

// File: rtl/adc_chsel_pkg.sv
package adc_chsel_pkg;

    localparam int REG_W  = 8;
    localparam int REF_W  = 2;
    localparam int CHAN_W = 5;
    localparam int RES_W  = 10;
    localparam int VIEW_W = 16;
    localparam int PAD_W  = VIEW_W - RES_W;

    typedef enum logic [REF_W-1:0] {
        REF_EXT_PIN  = 2'b00,
        REF_SUPPLY   = 2'b01,
        REF_INT_1V1  = 2'b10,
        REF_INT_2V56 = 2'b11
    } ref_code_t;

    typedef struct packed {
        ref_code_t         ref_sel;
        logic              left_adj;
        logic [CHAN_W-1:0] chan_sel;
    } ctrl_t;

    typedef struct packed {
        ref_code_t         ref_sel;
        logic [CHAN_W-1:0] chan_sel;
    } applied_t;

    localparam ctrl_t    CTRL_RESET    = '{ref_sel: REF_EXT_PIN, left_adj: 1'b0, chan_sel: '0};
    localparam applied_t APPLIED_RESET = '{ref_sel: REF_EXT_PIN, chan_sel: '0};

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c = ctrl_t'(raw);
        return c;
    endfunction

    function automatic applied_t take_applied(input ctrl_t c);
        applied_t a;
        a.ref_sel  = c.ref_sel;
        a.chan_sel = c.chan_sel;
        return a;
    endfunction

    function automatic logic [VIEW_W-1:0] align_result(input logic [RES_W-1:0] res,
                                                       input logic left);
        logic [VIEW_W-1:0] v;
        if (left) v = {res, {PAD_W{1'b0}}};
        else      v = {{PAD_W{1'b0}}, res};
        return v;
    endfunction

endpackage

// File: rtl/adc_chsel_visible.sv
module adc_chsel_visible
    import adc_chsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            cur_q,
    output ctrl_t            cur_next
);
    always_comb begin
        cur_next = cur_q;
        if (wr_en) cur_next = unpack_ctrl(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= CTRL_RESET;
        else     cur_q <= cur_next;
    end
endmodule

// File: rtl/adc_chsel_defer.sv
module adc_chsel_defer
    import adc_chsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     conv_busy,
    input  logic     conv_done,
    input  ctrl_t    cur_next,
    output applied_t applied_q
);
    logic apply_now;

    // Track the visible value whenever no conversion is open, or at its final cycle.
    assign apply_now = !conv_busy || conv_done;

    always_ff @(posedge clk) begin
        if (rst)            applied_q <= APPLIED_RESET;
        else if (apply_now) applied_q <= take_applied(cur_next);
    end
endmodule

// File: rtl/adc_chsel_format.sv
module adc_chsel_format
    import adc_chsel_pkg::*;
(
    input  logic [RES_W-1:0]  raw_result,
    input  logic              left_adj,
    output logic [VIEW_W-1:0] data_view
);
    always_comb data_view = align_result(raw_result, left_adj);
endmodule

// File: rtl/adc_chsel_reg.sv
module adc_chsel_reg
    import adc_chsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  raw_result,
    output logic [REF_W-1:0]  eff_ref,
    output logic [CHAN_W-1:0] eff_chan,
    output logic [VIEW_W-1:0] data_view
);
    ctrl_t    cur_q;
    ctrl_t    cur_next;
    applied_t applied_q;

    adc_chsel_visible u_vis (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cur_q    (cur_q),
        .cur_next (cur_next)
    );

    adc_chsel_defer u_def (
        .clk       (clk),
        .rst       (rst),
        .conv_busy (conv_busy),
        .conv_done (conv_done),
        .cur_next  (cur_next),
        .applied_q (applied_q)
    );

    adc_chsel_format u_fmt (
        .raw_result (raw_result),
        .left_adj   (cur_q.left_adj),
        .data_view  (data_view)
    );

    assign rd_data  = cur_q;
    assign eff_ref  = applied_q.ref_sel;
    assign eff_chan = applied_q.chan_sel;
endmodule

// File: rtl/adc_chsel_chk.sv
module adc_chsel_chk
    import adc_chsel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              conv_busy,
    input logic              conv_done,
    input logic [RES_W-1:0]  raw_result,
    input logic [REF_W-1:0]  eff_ref,
    input logic [CHAN_W-1:0] eff_chan,
    input logic [VIEW_W-1:0] data_view
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && eff_ref == '0 && eff_chan == '0));

    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data)));

    p_idle_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !conv_busy |=> (eff_ref == rd_data[7:6] && eff_chan == rd_data[4:0]));

    p_ref_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_busy && !conv_done) |=> $stable(eff_ref));

    p_chan_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_busy && !conv_done) |=> $stable(eff_chan));

    p_done_apply_r6: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> (eff_ref == rd_data[7:6] && eff_chan == rd_data[4:0]));

    p_left_fmt_r8: assert property (@(posedge clk) disable iff (rst)
        rd_data[5] |-> (data_view == {raw_result, {PAD_W{1'b0}}}));

    p_right_fmt_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_data[5] |-> (data_view == {{PAD_W{1'b0}}, raw_result}));
endmodule

bind adc_chsel_reg adc_chsel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .raw_result (raw_result),
    .eff_ref    (eff_ref),
    .eff_chan   (eff_chan),
    .data_view  (data_view)
);

// File: tb/sim_adc_chsel_reg.sv
module sim_adc_chsel_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        conv_busy = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  raw_result = '0;
    logic [1:0]  eff_ref;
    logic [4:0]  eff_chan;
    logic [15:0] data_view;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_chsel_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .conv_busy(conv_busy), .conv_done(conv_done), .raw_result(raw_result),
        .eff_ref(eff_ref), .eff_chan(eff_chan), .data_view(data_view)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", 16'(rd_data), 16'h0);
        check("R1 eff_ref", 16'(eff_ref), 16'h0);
        check("R1 eff_chan", 16'(eff_chan), 16'h0);
    endtask

    task automatic t_readback();
        write_reg(8'hA5);
        check("R2 readback A5", 16'(rd_data), 16'hA5);
        write_reg(8'h5A);
        check("R2 readback 5A", 16'(rd_data), 16'h5A);
    endtask

    task automatic t_idle_apply();
        write_reg(8'hC3);
        check("R3 idle ref", 16'(eff_ref), 16'h3);
        check("R3 idle chan", 16'(eff_chan), 16'h3);
    endtask

    task automatic t_deferred();
        conv_busy = 1'b1;
        @(negedge clk);
        write_reg(8'h45);
        check("R10 rd during busy", 16'(rd_data), 16'h45);
        check("R4 ref held", 16'(eff_ref), 16'h3);
        check("R5 chan held", 16'(eff_chan), 16'h3);
        write_reg(8'h82);
        repeat (3) @(negedge clk);
        check("R4 ref still held", 16'(eff_ref), 16'h3);
        check("R5 chan still held", 16'(eff_chan), 16'h2 ^ 16'h1);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R6 last ref applied", 16'(eff_ref), 16'h2);
        check("R6 last chan applied", 16'(eff_chan), 16'h2);
        conv_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_align();
        raw_result = 10'h2AB;
        conv_busy = 1'b1;
        @(negedge clk);
        write_reg(8'h24);
        check("R7 R8 left during busy", data_view, 16'hAAC0);
        check("R5 chan frozen on align write", 16'(eff_chan), 16'h2);
        write_reg(8'h04);
        check("R9 right during busy", data_view, 16'h02AB);
        write_reg(8'h20);
        raw_result = 10'h3FF;
        #1;
        check("R8 left all ones", data_view, 16'hFFC0);
        conv_busy = 1'b0;
        @(negedge clk);
        check("R3 idle after busy", 16'(eff_chan), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_idle_apply();
        t_deferred();
        t_align();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule